// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers interrupt sources, one per bit, into a bank of word registers on a simple memory-mapped register bus. Hardware event pulses latch into a cause register. Software can also raise causes through a write-only set register. A mask register gates which pending causes reach a single interrupt line. The mask can be written whole, or have bits set or cleared through two write-one aliases.

Each cause bit is cleared in one of two ways, chosen per bit by a control register. It is either cleared when software writes a 1 to it, or cleared as a side effect of being read. A masked view of the cause register shows only the unmasked pending bits. Accesses through that view clear the underlying cause bits under the same per-bit rule, limited to the bits the view shows.

An access is one cycle with `bus_sel` high. Read data is registered and appears the cycle after the read.

Top module: `icm_regbank`

## Requirements
- R1: The word index on `bus_addr` selects the register as follows: 0 control, 1 cause, 2 masked cause, 3 cause set, 4 mask value, 5 mask set, 6 mask clear. Index 7 reads zero and ignores writes. Bit i of every register belongs to source i.
- R2: The control register is written whole and reads back its value. For each bit, a control value of 0 selects write-one-to-clear for that cause bit, and a value of 1 selects clear-on-read.
- R3: A cause bit whose control bit is 0 stays set across reads. It is cleared by writing 1 to that bit of the cause register. Writing 0 leaves it unchanged.
- R4: A read of the cause register returns the value from before the access. It clears exactly the set bits whose control bit is 1. Writing 1 to a cause bit whose control bit is 1 has no effect.
- R5: Writing 1 to a bit of the cause set register sets that cause bit. Zero bits have no effect.
- R6: A read of the masked cause register returns the cause ANDed with the inverted mask. A mask bit of 1 hides its source.
- R7: Accesses to the masked cause register clear underlying cause bits by the rule of R3 or R4, but only bits whose mask bit is 0. Masked cause bits are kept.
- R8: The mask value register is written whole and reads back its value. Writing 1s to mask set sets those mask bits. Writing 1s to mask clear clears them. Zero bits leave the mask unchanged.
- R9: A hardware event on a bit in the same cycle as a clear of that bit leaves the bit set.
- R10: `irq_out` is high in the cycle after the masked cause is nonzero, and low in the cycle after it is zero.
- R11: After reset, cause, control, mask and `irq_out` are zero. Reads of the cause set, mask set, mask clear and unused registers return zero. `bus_rdata` returns the selected value one cycle after a read and is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| hw_event | input | NSRC | Per-source event pulses |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the bank with the default width of 32 sources, so patterns reach bit 31 and mix both clearing rules across one word. A mask with holes in it lets a single access through the masked view show which bits are cleared and which are kept. Events are driven in the same cycle as write-one clears and clear-on-read reads of the same bits, so the cases where an event wins are covered.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_CTL    = 3'd0,
    REG_CAUSE  = 3'd1,
    REG_MCAUSE = 3'd2,
    REG_CSET   = 3'd3,
    REG_MVAL   = 3'd4,
    REG_MSET   = 3'd5,
    REG_MCLR   = 3'd6,
    REG_NONE   = 3'd7
  } icm_reg_e;
endpackage

// File: rtl/icm_decode.sv
module icm_decode
  import icm_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  output logic              wr_ctl,
  output logic              wr_cause,
  output logic              wr_mcause,
  output logic              wr_cset,
  output logic              wr_mval,
  output logic              wr_mset,
  output logic              wr_mclr,
  output logic              rd_cause,
  output logic              rd_mcause,
  output logic              rd_zero
);
  icm_reg_e sel_reg;
  logic     do_wr, do_rd;

  always_comb begin
    sel_reg   = icm_reg_e'(bus_addr);
    do_wr     = bus_sel && bus_wr;
    do_rd     = bus_sel && !bus_wr;
    wr_ctl    = do_wr && (sel_reg == REG_CTL);
    wr_cause  = do_wr && (sel_reg == REG_CAUSE);
    wr_mcause = do_wr && (sel_reg == REG_MCAUSE);
    wr_cset   = do_wr && (sel_reg == REG_CSET);
    wr_mval   = do_wr && (sel_reg == REG_MVAL);
    wr_mset   = do_wr && (sel_reg == REG_MSET);
    wr_mclr   = do_wr && (sel_reg == REG_MCLR);
    rd_cause  = do_rd && (sel_reg == REG_CAUSE);
    rd_mcause = do_rd && (sel_reg == REG_MCAUSE);
    rd_zero   = do_rd && ((sel_reg == REG_CSET) || (sel_reg == REG_MSET) ||
                          (sel_reg == REG_MCLR) || (sel_reg == REG_NONE));
  end
endmodule

// File: rtl/icm_ctrl_regs.sv
module icm_ctrl_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            wr_mval,
  input  logic            wr_mset,
  input  logic            wr_mclr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] ctl_q,
  output logic [NSRC-1:0] mask_q
);
  function automatic logic [NSRC-1:0] mask_next(
    input logic [NSRC-1:0] cur, input logic [NSRC-1:0] d,
    input logic full, input logic set, input logic clr);
    logic [NSRC-1:0] m;
    m = full ? d : cur;
    if (set) m = m | d;
    if (clr) m = m & ~d;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata;
      mask_q <= mask_next(mask_q, wdata, wr_mval, wr_mset, wr_mclr);
    end
  end

  // R8: set alias forces ones, clear alias forces zeros
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(wdata)) == $past(wdata)));
  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/icm_cause.sv
module icm_cause #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_event,
  input  logic [NSRC-1:0] ctl_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] wdata,
  input  logic            wr_cause,
  input  logic            wr_mcause,
  input  logic            wr_cset,
  input  logic            rd_cause,
  input  logic            rd_mcause,
  output logic [NSRC-1:0] cause_q,
  output logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] set_bits
);
  function automatic logic [NSRC-1:0] clear_vec(
    input logic [NSRC-1:0] ctl, input logic [NSRC-1:0] msk,
    input logic [NSRC-1:0] d, input logic w_c, input logic w_m,
    input logic r_c, input logic r_m);
    logic [NSRC-1:0] c;
    c = '0;
    if (w_c) c = c | (d & ~ctl);
    if (w_m) c = c | (d & ~ctl & ~msk);
    if (r_c) c = c | ctl;
    if (r_m) c = c | (ctl & ~msk);
    return c;
  endfunction

  always_comb begin
    clr_bits = clear_vec(ctl_q, mask_q, wdata, wr_cause, wr_mcause, rd_cause, rd_mcause);
    set_bits = hw_event | (wr_cset ? wdata : '0);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           cause_q[i] <= 1'b0;
      else if (set_bits[i]) cause_q[i] <= 1'b1;
      else if (clr_bits[i]) cause_q[i] <= 1'b0;
    end
  end

  // R9: an event always leaves its bit set
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));
  // R5: no bit rises without an event or a software set
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(set_bits)) == '0));
  // R4: clear-on-read empties the clear-on-read bits absent events
  a_r4_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && hw_event == '0) |=> ((cause_q & $past(ctl_q)) == '0));
endmodule

// File: rtl/icm_regbank.sv
module icm_regbank
  import icm_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   hw_event,
  output logic              irq_out
);
  logic wr_ctl, wr_cause, wr_mcause, wr_cset, wr_mval, wr_mset, wr_mclr;
  logic rd_cause, rd_mcause, rd_zero;
  logic [NSRC-1:0] ctl_q, mask_q, cause_q, clr_bits, set_bits;
  logic [NSRC-1:0] masked_view, rd_value;
  logic            rd_any;

  icm_decode u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wr_ctl(wr_ctl), .wr_cause(wr_cause), .wr_mcause(wr_mcause),
    .wr_cset(wr_cset), .wr_mval(wr_mval), .wr_mset(wr_mset),
    .wr_mclr(wr_mclr), .rd_cause(rd_cause), .rd_mcause(rd_mcause),
    .rd_zero(rd_zero)
  );

  icm_ctrl_regs #(.NSRC(NSRC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_mval(wr_mval),
    .wr_mset(wr_mset), .wr_mclr(wr_mclr), .wdata(bus_wdata),
    .ctl_q(ctl_q), .mask_q(mask_q)
  );

  icm_cause #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .ctl_q(ctl_q),
    .mask_q(mask_q), .wdata(bus_wdata), .wr_cause(wr_cause),
    .wr_mcause(wr_mcause), .wr_cset(wr_cset), .rd_cause(rd_cause),
    .rd_mcause(rd_mcause), .cause_q(cause_q), .clr_bits(clr_bits),
    .set_bits(set_bits)
  );

  always_comb begin
    masked_view = cause_q & ~mask_q;
    rd_any      = bus_sel && !bus_wr;
    rd_value    = '0;
    if (rd_any && !rd_zero) begin
      unique case (icm_reg_e'(bus_addr))
        REG_CTL:    rd_value = ctl_q;
        REG_CAUSE:  rd_value = cause_q;
        REG_MCAUSE: rd_value = masked_view;
        REG_MVAL:   rd_value = mask_q;
        default:    rd_value = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_value;
      irq_out   <= |masked_view;
    end
  end

  // R4: clear-on-read returns the value from before the clear
  a_r4_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cause |=> (bus_rdata == $past(cause_q)));
  // R11: write-only and unused registers read zero
  a_r11_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |=> (bus_rdata == '0));
  // R10: the interrupt only rises after an unmasked pending cause
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(masked_view != '0));
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(masked_view == '0));
  // R7: masked-view accesses never clear masked bits
  a_r7_keep_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mcause || rd_mcause) |=> ((cause_q & $past(cause_q & mask_q)) == $past(cause_q & mask_q)));
endmodule

// File: tb/tb_icm_regbank.sv
`timescale 1ns/1ps
module tb_icm_regbank;
  localparam int NSRC = 32;
  typedef struct { logic [NSRC-1:0] v; string tag; } exp_t;

  logic            clk = 0, rst_n = 0;
  logic            bus_sel = 0, bus_wr = 0;
  logic [2:0]      bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0, hw_event = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            irq_out;

  int total = 0, bad = 0;
  exp_t q[$];
  logic [NSRC-1:0] m_cause = '0, m_ctl = '0, m_mask = '0;
  logic            m_irq = 0;
  bit              finished = 0;

  always #5 clk = ~clk;

  icm_regbank #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_event(hw_event), .irq_out(irq_out)
  );

  task automatic check(input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data one step after each read edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(bus_rdata, e.v, e.tag);
    end
  end

  // one bus cycle with optional events; updates the reference model
  task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                     input logic [NSRC-1:0] d, input logic [NSRC-1:0] ev,
                     input string tag);
    logic [NSRC-1:0] clr, setv, rv;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; hw_event = ev;
    m_irq = |(m_cause & ~m_mask);
    clr = '0; setv = ev; rv = '0;
    if (s && !w) begin
      case (a)
        3'd0: rv = m_ctl;
        3'd1: begin rv = m_cause; clr = m_ctl; end
        3'd2: begin rv = m_cause & ~m_mask; clr = m_ctl & ~m_mask; end
        3'd4: rv = m_mask;
        default: rv = '0;
      endcase
      q.push_back('{v: rv, tag: tag});
    end
    if (s && w) begin
      case (a)
        3'd0: m_ctl = d;
        3'd1: clr = d & ~m_ctl;
        3'd2: clr = d & ~m_ctl & ~m_mask;
        3'd3: setv = setv | d;
        3'd4: m_mask = d;
        3'd5: m_mask = m_mask | d;
        3'd6: m_mask = m_mask & ~d;
        default: ;
      endcase
    end
    m_cause = (m_cause & ~clr) | setv;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; hw_event = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1, 0, a, '0, '0, tag);
  endtask
  task automatic wr(input logic [2:0] a, input logic [NSRC-1:0] d, input string tag);
    cyc(1, 1, a, d, '0, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 3'd0, '0, '0, "idle");
  endtask
  task automatic chk_irq(input string tag);
    #1 check({31'b0, irq_out}, {31'b0, m_irq}, tag);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check({31'b0, irq_out}, 32'd0, "R11 irq after reset");
    for (int i = 0; i < 8; i++) rd(3'(i), $sformatf("R11 R1 reset read idx %0d", i));
    // W1C basics
    cyc(0, 0, 3'd0, '0, 32'h8000_0011, "event");
    idle(); chk_irq("R10 irq rises");
    rd(3'd1, "R3 cause read 1"); rd(3'd1, "R3 cause read persists");
    wr(3'd1, 32'h0000_0010, "R3 w1c");
    rd(3'd1, "R3 after w1c");
    // clear-on-read selection
    wr(3'd0, 32'h0000_FF00, "R2 ctl write");
    rd(3'd0, "R2 ctl readback");
    cyc(0, 0, 3'd0, '0, 32'h0000_0F00, "event");
    rd(3'd1, "R4 cor returns old"); rd(3'd1, "R4 cor cleared");
    wr(3'd1, 32'h8000_0001, "R3 w1c rest");
    cyc(0, 0, 3'd0, '0, 32'h0000_0100, "event");
    wr(3'd1, 32'h0000_0100, "R4 w1c ignored on cor bit");
    rd(3'd1, "R4 cor bit kept by write");
    rd(3'd1, "R4 cor bit gone");
    idle(); chk_irq("R10 irq falls");
    // software set
    wr(3'd3, 32'h0000_0006, "R5 cset");
    rd(3'd1, "R5 cause after cset");
    // mask registers
    wr(3'd4, 32'hFFFF_0000, "R8 mval");
    rd(3'd4, "R8 mval readback");
    wr(3'd5, 32'h0000_00F0, "R8 mset");
    wr(3'd6, 32'h0F00_0000, "R8 mclr");
    rd(3'd4, "R8 mask after aliases");
    // masked view
    cyc(0, 0, 3'd0, '0, 32'h0F10_00F8, "event");
    rd(3'd2, "R6 masked read");
    wr(3'd2, 32'hFFFF_FFFF, "R7 masked w1c");
    rd(3'd1, "R7 masked bits kept after w1c");
    wr(3'd5, 32'h0000_0300, "R8 mset 2");
    cyc(0, 0, 3'd0, '0, 32'h0000_FF00, "event");
    rd(3'd2, "R7 masked cor read");
    rd(3'd1, "R7 masked cor kept hidden bits");
    // event wins
    wr(3'd4, 32'h0000_0000, "R8 mval zero");
    cyc(0, 0, 3'd0, '0, 32'h0000_0004, "event");
    cyc(1, 1, 3'd1, 32'h0000_0004, 32'h0000_0004, "R9 w1c vs event");
    rd(3'd1, "R9 bit survives w1c");
    cyc(1, 0, 3'd1, '0, 32'h0000_0200, "R9 cor read with event");
    rd(3'd1, "R9 bit survives cor");
    // irq masked off
    wr(3'd4, 32'hFFFF_FFFF, "R8 mask all");
    idle(); idle(); chk_irq("R10 irq masked");
    wr(3'd6, 32'h0000_0004, "R8 unmask bit2");
    idle(); chk_irq("R10 irq unmasked");
    // write-only / unused
    wr(3'd7, 32'hFFFF_FFFF, "R1 idx7 write");
    rd(3'd3, "R11 cset reads 0"); rd(3'd5, "R11 mset reads 0");
    rd(3'd6, "R11 mclr reads 0"); rd(3'd7, "R11 idx7 reads 0");
    rd(3'd0, "R1 ctl untouched"); rd(3'd4, "R1 mask untouched");
    rd(3'd1, "R1 cause untouched");
    idle();
    check(bus_rdata, '0, "R11 rdata zero when idle");
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule